// File: doc/BRIEF.md
# Segmented Mismatch-Shaping DAC Encoder

This block turns an 8-bit unsigned DAC code into eight single-bit element drives. An external summing network adds the drives as four pairs. Both elements of a pair carry the same binary weight, and the pair weights are 8, 4, 2 and 1. The encoder runs on every clock with no enable. It first requantizes the code to an integer level between 0 and 30. A first-order error-feedback loop does this, so the quantization error is highpass shaped. The level is then split from the heaviest pair down to the lightest. Each pair receives zero, one or two units.

When a pair receives exactly one unit, the encoder must choose which of its two elements fires. In the shaping modes, a one-bit state per pair alternates that choice. The mismatch between the two elements then appears at the output as first-order highpass shaped noise. A random mode takes the choice from a free-running LFSR instead. A static mode always uses the lower element. A dithered shaping mode adds one LFSR bit to the requantizer on each cycle to break up idle tones.

The code and mode inputs each pass through two synchronizing flops before the encoding logic. The element drives are registered.

Top module: `mms_dac_encoder`

## Requirements
- R1: A synchronous active-low reset drives every element output to 0 on the clock edge where reset is sampled low. The reset also clears the error accumulator and the pair states, and it loads a nonzero LFSR seed.
- R2: The output is weighted in pairs: bits 7 and 6 weigh 8, bits 5 and 4 weigh 4, bits 3 and 2 weigh 2, and bits 1 and 0 weigh 1. The weighted sum always lies in 0..30.
- R3: In mode 1 (shaping, no dither), with the code held at C, the weighted sums of any 256 consecutive outputs add up to exactly 30*C.
- R4: A change on the code input first shows at the outputs on the third rising edge after it is applied. The two edges before that still show the old code.
- R5: In mode 0 (static), a pair that receives one unit drives its lower bit (bit 2s), never its upper bit (bit 2s+1).
- R6: The level is split from the top down. Pair s drives both elements when the level remaining for pair s and the pairs below it is at least twice its weight. It drives one element when that remainder is at least its weight, and none otherwise.
- R7: In modes 1 and 3, the one-unit choices of each pair alternate between its two elements. The first such choice after reset uses the lower element.
- R8: In mode 2 (random), the element chosen for a one-unit pair follows a pseudo-random bit. With code 128 held for 256 cycles, each pair uses both of its elements and repeats an element at least once.
- R9: In mode 3 (dithered shaping), with the code held at C, the sum over any 256 consecutive outputs lies within 30*C..30*C+1.
- R10: Cycles in mode 0 or mode 2 leave the pair states unchanged. After them, mode 1 resumes the alternation from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the encoder advances on every rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dac_code | input | 8 | Unsigned DAC code, asynchronous to the encoder |
| mode_sel | input | 2 | 0 static, 1 shaping, 2 random, 3 shaping with dither |
| elem_drive | output | 8 | Element drives, pairs at bits {7,6},{5,4},{3,2},{1,0} |

## Verification
The bench uses the default build: an 8-bit code, four pairs and a 16-bit LFSR. This gives the 0..30 level range, and over a 256-cycle window the requantizer error returns exactly to its starting value. That property turns the mode 1 average and the mode 3 dither bound into exact integer checks. Code 128 maps to a level of exactly 15 with zero residual, so every pair carries one unit on every cycle. This exposes the element alternation, the hold of the pair states across modes 0 and 2, and the random choice cycle by cycle.

// File: rtl/mms_dac_pkg.sv
// Shared types for the mismatch-shaping DAC encoder.
// Assumes the mode input is two bits wide with the encoding below.
package mms_dac_pkg;
    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_SHAPE  = 2'd1,
        MODE_RANDOM = 2'd2,
        MODE_DITHER = 2'd3
    } enc_mode_e;

    // True for the modes that alternate the elements of a pair.
    function automatic logic is_shaping(input enc_mode_e m);
        return (m == MODE_SHAPE) || (m == MODE_DITHER);
    endfunction
endpackage

// File: rtl/mms_dac_sync.sv
// Two-flop synchronizer for a bus of asynchronous inputs.
// Assumes each bit may be sampled independently (quasi-static inputs).
module mms_dac_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/mms_dac_lfsr.sv
// Free-running Galois LFSR that supplies the random element choices and the dither bit.
// Assumes a nonzero seed and a tap mask that gives a long sequence.
module mms_dac_lfsr #(
    parameter int          W     = 16,
    parameter int          NOUT  = 4,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NOUT-1:0] rnd_bits,
    output logic            dither_bit
);
    logic [W-1:0] q;

    // Shift right and apply the taps when the bit leaving the register is set.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end

    assign rnd_bits   = q[NOUT-1:0];
    assign dither_bit = q[W-1];
endmodule

// File: rtl/mms_dac_requant.sv
// First-order error-feedback requantizer: maps an IN_W-bit code to a level 0..LMAX.
// Over time the level averages code*LMAX/2^IN_W; the residual is carried to the next cycle.
module mms_dac_requant #(
    parameter int IN_W  = 8,
    parameter int LMAX  = 30,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  code,
    input  logic             dither,
    output logic [LVL_W-1:0] level
);
    localparam int PROD_W = IN_W + LVL_W + 1;

    logic [IN_W-1:0]   err_q;
    logic [PROD_W-1:0] total;

    // Scaled code plus carried residual plus optional dither.
    always_comb begin
        total = PROD_W'(code) * PROD_W'(LMAX) + PROD_W'(err_q) + PROD_W'(dither);
        level = total[IN_W +: LVL_W];
    end

    // Keep the fractional part as the next cycle's residual.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= total[IN_W-1:0];
    end
endmodule

// File: rtl/mms_dac_split.sv
// Top-down split of a level across NSEG pairs of binary weight 2^s.
// Assumes the level does not exceed 2*(2^NSEG-1), so every pair count is 0, 1 or 2.
module mms_dac_split #(
    parameter int NSEG  = 4,
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0]     level,
    output logic [NSEG-1:0][1:0] seg_cnt
);
    // Greedy assignment from the heaviest pair down.
    always_comb begin
        int rem;
        rem = int'(level);
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (rem >= (2 << s)) begin
                seg_cnt[s] = 2'd2;
                rem        = rem - (2 << s);
            end else if (rem >= (1 << s)) begin
                seg_cnt[s] = 2'd1;
                rem        = rem - (1 << s);
            end else begin
                seg_cnt[s] = 2'd0;
            end
        end
    end
endmodule

// File: rtl/mms_dac_pair.sv
// Element selector for one pair of equal-weight elements.
// Holds the one-bit alternation state; drv[0] is the lower element, drv[1] the upper.
module mms_dac_pair
    import mms_dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cnt,
    input  enc_mode_e  mode,
    input  logic       rnd,
    output logic [1:0] drv
);
    logic alt_q;
    logic pick_upper;

    // Choose the element used for a single unit.
    always_comb begin
        case (mode)
            MODE_STATIC: pick_upper = 1'b0;
            MODE_RANDOM: pick_upper = rnd;
            default:     pick_upper = alt_q;
        endcase
        case (cnt)
            2'd2:    drv = 2'b11;
            2'd1:    drv = pick_upper ? 2'b10 : 2'b01;
            default: drv = 2'b00;
        endcase
    end

    // Toggle the alternation state after each single-unit cycle in a shaping mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                alt_q <= 1'b0;
        else if (is_shaping(mode) && cnt == 2'd1)  alt_q <= ~alt_q;
    end
endmodule

// File: rtl/mms_dac_encoder.sv
// Segmented mismatch-shaping DAC encoder (top).
// Synchronizes code and mode, requantizes, splits across pairs and registers the element drives.
module mms_dac_encoder
    import mms_dac_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int NSEG   = 4,
    parameter int LFSR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   dac_code,
    input  logic [1:0]        mode_sel,
    output logic [2*NSEG-1:0] elem_drive
);
    localparam int LMAX  = 2 * ((1 << NSEG) - 1);
    localparam int LVL_W = $clog2(LMAX + 1);

    logic [IN_W+1:0]       sync_q;
    logic [IN_W-1:0]       code_s;
    enc_mode_e             mode_s;
    logic [NSEG-1:0]       rnd_bits;
    logic                  dither_raw;
    logic [LVL_W-1:0]      level;
    logic [NSEG-1:0][1:0]  seg_cnt;
    logic [2*NSEG-1:0]     drv_next;

    mms_dac_sync #(.W(IN_W + 2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({mode_sel, dac_code}), .d_sync(sync_q)
    );

    // Unpack the synchronized bus.
    assign code_s = sync_q[IN_W-1:0];
    assign mode_s = enc_mode_e'(sync_q[IN_W +: 2]);

    mms_dac_lfsr #(.W(LFSR_W), .NOUT(NSEG)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd_bits(rnd_bits), .dither_bit(dither_raw)
    );

    mms_dac_requant #(.IN_W(IN_W), .LMAX(LMAX), .LVL_W(LVL_W)) u_rq (
        .clk(clk), .rst_n(rst_n), .code(code_s),
        .dither(dither_raw && (mode_s == MODE_DITHER)), .level(level)
    );

    mms_dac_split #(.NSEG(NSEG), .LVL_W(LVL_W)) u_split (
        .level(level), .seg_cnt(seg_cnt)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_pair
        mms_dac_pair u_pair (
            .clk(clk), .rst_n(rst_n), .cnt(seg_cnt[s]), .mode(mode_s),
            .rnd(rnd_bits[s]), .drv(drv_next[2*s +: 2])
        );
    end

    // Output register for the element drives.
    always_ff @(posedge clk) begin
        if (!rst_n) elem_drive <= '0;
        else        elem_drive <= drv_next;
    end
endmodule

// File: rtl/mms_dac_checker.sv
// Assertion checker for mms_dac_encoder, bound to every instance of the top.
// Tracks the mode that produced each output and the last shaping choice per pair.
module mms_dac_checker
    import mms_dac_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int NSEG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IN_W-1:0]   code_in,
    input logic [2*NSEG-1:0] drive,
    input logic [IN_W-1:0]   code_s,
    input enc_mode_e         mode_s
);
    enc_mode_e       mode_d;
    logic [1:0]      up_cnt;
    logic [NSEG-1:0] last_up;
    logic [NSEG-1:0] seen;

    // Mode behind the current output, and cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_d <= MODE_STATIC;
            up_cnt <= '0;
        end else begin
            mode_d <= mode_s;
            if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (drive == '0));

    a_r4_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (code_s == $past(code_in, 2)));

    for (genvar s = 0; s < NSEG; s++) begin : g_chk
        logic single, upper, full;
        int   below;
        assign single = drive[2*s] ^ drive[2*s+1];
        assign upper  = drive[2*s+1];
        assign full   = drive[2*s] & drive[2*s+1];

        // Weighted sum of the pairs below this one.
        always_comb begin
            below = 0;
            for (int k = 0; k < s; k++)
                below += (int'(drive[2*k]) + int'(drive[2*k+1])) << k;
        end

        // Last element used by this pair in a shaping mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_up[s] <= 1'b0;
                seen[s]    <= 1'b0;
            end else if (is_shaping(mode_d) && single) begin
                last_up[s] <= upper;
                seen[s]    <= 1'b1;
            end
        end

        a_r5_static_lower: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_d == MODE_STATIC) |-> !(upper && !drive[2*s]));

        a_r6_greedy_split: assert property (@(posedge clk) disable iff (!rst_n)
            !full |-> (below < (1 << s)));

        a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
            (is_shaping(mode_d) && single) |-> (seen[s] ? (upper != last_up[s]) : !upper));
    end
endmodule

bind mms_dac_encoder mms_dac_checker #(.IN_W(IN_W), .NSEG(NSEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .code_in(dac_code), .drive(elem_drive),
    .code_s(code_s), .mode_s(mode_s)
);

// File: tb/sim_mms_dac_encoder.sv
// Directed bench for mms_dac_encoder: one task per scenario, each checking its own results.
module sim_mms_dac_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dac_code = 8'd0;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] elem_drive;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mms_dac_encoder u0 (
        .clk(clk), .rst_n(rst_n), .dac_code(dac_code),
        .mode_sel(mode_sel), .elem_drive(elem_drive)
    );

    always #10 clk = ~clk;

    function automatic int wsum(input logic [7:0] d);
        int t = 0;
        for (int s = 0; s < 4; s++) t += (int'(d[2*s]) + int'(d[2*s+1])) << s;
        return t;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 and R6: range and top-down split of one output word.
    task automatic check_word(input logic [7:0] d);
        int rem, exp_cnt, got;
        rem = wsum(d);
        check("R2", int'(rem <= 30), 1);
        for (int s = 3; s >= 0; s--) begin
            exp_cnt = (rem >= (2 << s)) ? 2 : (rem >= (1 << s)) ? 1 : 0;
            rem     = rem - exp_cnt * (1 << s);
            got     = int'(d[2*s]) + int'(d[2*s+1]);
            check("R6", got, exp_cnt);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dac_code = 8'd0; mode_sel = 2'd1;
        repeat (3) @(negedge clk);
        check("R1", int'(elem_drive), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", int'(elem_drive), 0);
    endtask

    // R4: code change shows on the third edge; first level for 255 from zero residual is 29.
    task automatic t_latency();
        do_reset();
        dac_code = 8'd255;
        @(negedge clk); check("R4", wsum(elem_drive), 0);
        @(negedge clk); check("R4", wsum(elem_drive), 0);
        @(negedge clk); check("R4", wsum(elem_drive), 29);
    endtask

    // R3/R9/R5/R7: 256-output window with constant code and mode.
    task automatic t_window(input logic [7:0] c, input logic [1:0] m);
        int total = 0;
        logic [3:0] last_up = '0, seen = '0;
        @(negedge clk);
        dac_code = c; mode_sel = m;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            check_word(elem_drive);
            total += wsum(elem_drive);
            for (int s = 0; s < 4; s++) begin
                if (elem_drive[2*s] ^ elem_drive[2*s+1]) begin
                    if (m == 2'd0) check("R5", int'(elem_drive[2*s+1]), 0);
                    if (m[0] && seen[s]) check("R7", int'(elem_drive[2*s+1]), int'(!last_up[s]));
                    last_up[s] = elem_drive[2*s+1];
                    seen[s]    = 1'b1;
                end
            end
            @(negedge clk);
        end
        if (m == 2'd3) begin
            check("R9", int'(total >= 30 * int'(c)), 1);
            check("R9", int'(total <= 30 * int'(c) + 1), 1);
        end else if (m == 2'd1) begin
            check("R3", total, 30 * int'(c));
        end
    endtask

    // R8: random mode at code 128, every pair single every cycle.
    task automatic t_random();
        int n_up[4], n_lo[4], n_rep[4];
        logic [3:0] prev = '0;
        @(negedge clk);
        dac_code = 8'd128; mode_sel = 2'd2;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) begin n_up[s] = 0; n_lo[s] = 0; n_rep[s] = 0; end
        for (int i = 0; i < 256; i++) begin
            check("R8", wsum(elem_drive), 15);
            for (int s = 0; s < 4; s++) begin
                if (elem_drive[2*s+1]) n_up[s]++; else n_lo[s]++;
                if (i > 0 && elem_drive[2*s+1] == prev[s]) n_rep[s]++;
                prev[s] = elem_drive[2*s+1];
            end
            @(negedge clk);
        end
        for (int s = 0; s < 4; s++) begin
            check("R8", int'(n_up[s] > 0 && n_lo[s] > 0), 1);
            check("R8", int'(n_rep[s] > 0), 1);
        end
    endtask

    // R7/R10: first shaping choice after reset is lower; modes 0 and 2 hold the states.
    task automatic t_hold();
        logic [1:0] modes[23];
        logic [7:0] expv[23];
        bit         st = 1'b0;
        do_reset();
        for (int i = 0; i < 23; i++) begin
            modes[i] = (i < 4) ? 2'd0 : (i < 9) ? 2'd1 : (i < 16) ? 2'd2 : (i < 19) ? 2'd0 : 2'd1;
            if (modes[i] == 2'd1) begin
                expv[i] = st ? 8'hAA : 8'h55;
                st = ~st;
            end else begin
                expv[i] = 8'h55;
            end
        end
        for (int i = 0; i < 26; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                if (modes[i-3] == 2'd2) check("R10", wsum(elem_drive), 15);
                else if (modes[i-3] == 2'd0) check("R5", int'(elem_drive), int'(expv[i-3]));
                else if (i - 3 < 9) check("R7", int'(elem_drive), int'(expv[i-3]));
                else check("R10", int'(elem_drive), int'(expv[i-3]));
            end
            if (i < 23) begin dac_code = 8'd128; mode_sel = modes[i]; end
        end
    endtask

    // R1: reset in mid-run clears the outputs on the next edge.
    task automatic t_mid_reset();
        @(negedge clk);
        dac_code = 8'd255; mode_sel = 2'd3;
        repeat (6) @(negedge clk);
        check("R2", int'(wsum(elem_drive) > 0), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(elem_drive), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_latency();
        do_reset();
        t_window(8'd128, 2'd1);
        t_window(8'd77, 2'd1);
        t_window(8'd255, 2'd1);
        t_window(8'd1, 2'd1);
        t_window(8'd0, 2'd1);
        t_window(8'd200, 2'd0);
        t_window(8'd200, 2'd3);
        t_window(8'd33, 2'd3);
        t_random();
        t_hold();
        t_mid_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule